// File: doc/BRIEF.md
# Recirculating Audio Echo Unit

This block is a streaming echo stage for signed audio samples. It sits between a serial audio receiver and a serial audio transmitter, and it processes one sample per input strobe. It holds a circular delay memory. The default is 2048 words, which is about 43 ms at a 48 kHz sample rate. For each sample it fetches a stored word and blends that word with the incoming sample under a programmable coefficient. The blend is sent out, and the same blend is written back into the memory. Earlier echoes therefore keep recirculating and decay over time.

A pitch mode splits the read side from the write side. The write pointer still steps once per sample. The read pointer steps twice per sample for an octave up, or once every other sample for an octave down. Clicks where the two pointers cross are accepted as they are.

After reset a small state machine clears the memory. It has two states:
- `ST_CLEAR` sweeps every address with zero.
- `ST_RUN` accepts samples.

There is one transition, `ST_CLEAR` to `ST_RUN`, and it is taken on the cycle that writes the last address. No transition leaves `ST_RUN` except reset.

Top module: `echo_ring_unit`

## Requirements
- R1: After reset the unit spends DEPTH = 2^ADDR_W cycles in `ST_CLEAR` writing zero to every word. During that time `out_valid` stays low and `in_valid` is ignored. Every word read afterwards starts at zero.
- R2: A sample taken on a clock edge with `in_valid` high in `ST_RUN` produces exactly one `out_valid` pulse, and that pulse is visible after the second clock edge from acceptance. No `out_valid` pulse appears without such a sample.
- R3: The output is y = (x·a + s·(256 − a) + 128) >>> 8, saturated to the signed 16-bit range. Here x is `in_sample`, s is the stored word, and a is `mix_coef`, an unsigned 8-bit value (a = 0 passes the stored word through).
- R4: In echo mode (`pitch_en` = 0) the word read for a sample is the word at the write address of that sample, read before the sample's own result overwrites it. The result y is both the output and the word written back.
- R5: The write address starts at 0 and steps by one per accepted sample, rolling over from DEPTH−1 to 0. In echo mode, sample n therefore reads the result of sample n−DEPTH.
- R6: In octave-up mode (`pitch_en` = 1, `pitch_down` = 0) the read pointer steps by 2 per accepted sample, modulo DEPTH.
- R7: In octave-down mode (`pitch_en` = 1, `pitch_down` = 1) the read pointer steps by 1 on every second accepted sample. Its phase starts at "hold" on the first sample after echo or octave-up mode.
- R8: Every echo-mode sample sets the read pointer to the next write address. Pitch mode entered after an echo-mode sample therefore begins reading at the current write address.
- R9: The write address changes only on an accepted sample, in every mode.
- R10: Samples may arrive on consecutive cycles. A read of the address written by the immediately preceding sample returns that sample's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe, one sample per high cycle |
| in_sample | input | 16 | Incoming signed sample |
| mix_coef | input | 8 | Weight of the incoming sample, unsigned fraction of 256 |
| pitch_en | input | 1 | 1 selects separate read pointer (pitch mode) |
| pitch_down | input | 1 | In pitch mode: 1 octave down, 0 octave up |
| out_valid | output | 1 | Result strobe |
| out_sample | output | 16 | Blended signed result |

## Verification
Each output is due two clock edges after the edge that accepts its sample. The bench drives at a falling edge and pushes the predicted value into a queue at that moment. Its monitor samples `out_valid` on every falling edge and pops one entry per pulse, which lands exactly two falling edges after the drive. A pulse with an empty queue counts as a failure. A queue that is non-empty at the end also counts as a failure. Strobes driven during the clearing sweep push nothing, so any output they caused would show as an unexpected pulse.

// File: rtl/echo_pkg.sv
package echo_pkg;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } fsm_state_t;

    typedef enum logic [1:0] {
        MODE_ECHO     = 2'd0,
        MODE_OCT_UP   = 2'd1,
        MODE_OCT_DOWN = 2'd2
    } ptr_mode_t;

endpackage

// File: rtl/echo_delay_mem.sv
module echo_delay_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // read-first: a same-edge write is not seen by the read
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= store[raddr];
        end
        if (we) begin
            store[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/echo_mix.sv
module echo_mix #(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 8
) (
    input  logic signed [SAMPLE_W-1:0] fresh,
    input  logic signed [SAMPLE_W-1:0] stored,
    input  logic        [COEF_W-1:0]   coef,
    output logic signed [SAMPLE_W-1:0] blend
);
    localparam int ACC_W = SAMPLE_W + COEF_W + 2;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (COEF_W - 1));
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (SAMPLE_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

    logic        [COEF_W:0]   w_old_u;
    logic signed [ACC_W-1:0]  fresh_e, stored_e, w_new, w_old, acc, scaled;

    always_comb begin
        w_old_u  = (COEF_W + 1)'(1 << COEF_W) - {1'b0, coef};
        fresh_e  = ACC_W'(fresh);
        stored_e = ACC_W'(stored);
        w_new    = $signed(ACC_W'(coef));
        w_old    = $signed(ACC_W'(w_old_u));
        acc      = fresh_e * w_new + stored_e * w_old + HALF;
        scaled   = acc >>> COEF_W;
        if (scaled > MAXV) begin
            blend = MAXV[SAMPLE_W-1:0];
        end else if (scaled < MINV) begin
            blend = MINV[SAMPLE_W-1:0];
        end else begin
            blend = scaled[SAMPLE_W-1:0];
        end
    end
endmodule

// File: rtl/echo_ptr_ctrl.sv
module echo_ptr_ctrl
    import echo_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              pitch_en,
    input  logic              pitch_down,
    output logic              accept,
    output logic              clearing,
    output logic [ADDR_W-1:0] clr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam logic [ADDR_W-1:0] LAST = '1;
    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO  = ADDR_W'(2);

    fsm_state_t        state_q, state_d;
    ptr_mode_t         mode;
    logic [ADDR_W-1:0] clr_cnt, wr_ptr, rd_ptr;
    logic              half_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (clr_cnt == LAST) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    // state outputs
    always_comb begin
        clearing = 1'b0;
        accept   = 1'b0;
        unique case (state_q)
            ST_CLEAR: clearing = 1'b1;
            ST_RUN:   accept   = in_valid;
        endcase
    end

    always_comb begin
        if (!pitch_en)      mode = MODE_ECHO;
        else if (pitch_down) mode = MODE_OCT_DOWN;
        else                mode = MODE_OCT_UP;
    end

    assign clr_addr = clr_cnt;
    assign wr_addr  = wr_ptr;
    assign rd_addr  = (mode == MODE_ECHO) ? wr_ptr : rd_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_cnt <= '0;
        end else if (clearing) begin
            clr_cnt <= clr_cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            half_q <= 1'b0;
        end else if (accept) begin
            wr_ptr <= wr_ptr + ONE;
            unique case (mode)
                MODE_ECHO: begin
                    rd_ptr <= wr_ptr + ONE;
                    half_q <= 1'b0;
                end
                MODE_OCT_UP: begin
                    rd_ptr <= rd_ptr + TWO;
                    half_q <= 1'b0;
                end
                MODE_OCT_DOWN: begin
                    if (half_q) rd_ptr <= rd_ptr + ONE;
                    half_q <= ~half_q;
                end
                default: half_q <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/echo_ring_unit.sv
module echo_ring_unit #(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 8,
    parameter int ADDR_W   = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [COEF_W-1:0]   mix_coef,
    input  logic                pitch_en,
    input  logic                pitch_down,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample
);
    logic                       accept, clearing;
    logic [ADDR_W-1:0]          clr_addr, rd_addr, wr_addr;
    logic                       s1_valid, s1_fwd;
    logic signed [SAMPLE_W-1:0] s1_x, s1_fwdval, rd_q, stored, blend;
    logic [COEF_W-1:0]          s1_a;
    logic [ADDR_W-1:0]          s1_waddr, mem_waddr;
    logic [SAMPLE_W-1:0]        mem_wdata;
    logic                       mem_we;

    echo_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .pitch_en   (pitch_en),
        .pitch_down (pitch_down),
        .accept     (accept),
        .clearing   (clearing),
        .clr_addr   (clr_addr),
        .rd_addr    (rd_addr),
        .wr_addr    (wr_addr)
    );

    assign mem_we    = clearing | s1_valid;
    assign mem_waddr = clearing ? clr_addr : s1_waddr;
    assign mem_wdata = clearing ? '0 : blend;

    echo_delay_mem #(.DATA_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (accept),
        .raddr (rd_addr),
        .rdata (rd_q)
    );

    // a write landing on the same edge as a read of that address is forwarded
    assign stored = s1_fwd ? s1_fwdval : rd_q;

    echo_mix #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) u_mix (
        .fresh  (s1_x),
        .stored (stored),
        .coef   (s1_a),
        .blend  (blend)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_fwd    <= 1'b0;
            s1_x      <= '0;
            s1_a      <= '0;
            s1_waddr  <= '0;
            s1_fwdval <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_x      <= in_sample;
                s1_a      <= mix_coef;
                s1_waddr  <= wr_addr;
                s1_fwd    <= s1_valid && (s1_waddr == rd_addr);
                s1_fwdval <= blend;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_sample <= blend;
        end
    end
endmodule

// File: rtl/echo_ring_checker.sv
module echo_ring_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept,
    input logic              clearing,
    input logic              out_valid,
    input logic              pitch_en,
    input logic              pitch_down,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rd_addr
);
    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (!rst_n)        cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        clearing |-> (!out_valid && !accept)); // R1
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && out_valid) |-> $past(accept, 2)); // R2
    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1))); // R5
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && !accept) |=> $stable(wr_addr)); // R9
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pitch_en && !pitch_down) |=>
        (!pitch_en || pitch_down || rd_addr == ADDR_W'($past(rd_addr) + 2'd2))); // R6
endmodule

bind echo_ring_unit echo_ring_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/echo_ring_unit_test.sv
module echo_ring_unit_test;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic [7:0]  mix_coef = '0;
    logic        pitch_en = 1'b0;
    logic        pitch_down = 1'b0;
    logic        out_valid;
    logic [15:0] out_sample;

    always #4 clk = ~clk; // 125 MHz

    echo_ring_unit #(.ADDR_W(AW)) uut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int m_mem [DEPTH];
    int m_wr = 0, m_rd = 0, m_half = 0, m_last_w = -1;
    bit m_prev_pitch = 1'b0;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    function automatic int blend_ref(int x, int s, int a);
        int v;
        v = x * a + s * (256 - a) + 128;
        v = v >>> 8;
        if (v > 32767)  v = 32767;
        if (v < -32768) v = -32768;
        return v;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drives one sample at a falling edge and predicts its result
    task automatic send(int x, int a, bit pen, bit pdn, int gap, string force_tag);
        int raddr, s, y;
        string tag;
        raddr = pen ? m_rd : m_wr;
        s = m_mem[raddr];
        y = blend_ref(x, s, a);
        if (force_tag != "")                 tag = force_tag;
        else if (raddr == m_last_w)          tag = "R10";
        else if (pen && !m_prev_pitch)       tag = "R8";
        else if (pen && pdn)                 tag = "R7";
        else if (pen)                        tag = "R6";
        else if (a == 0)                     tag = "R4";
        else if (m_wr == 0)                  tag = "R5";
        else                                 tag = "R3";
        m_mem[m_wr] = y;
        m_last_w = m_wr;
        if (!pen) begin
            m_rd = (m_wr + 1) % DEPTH;
            m_half = 0;
        end else if (!pdn) begin
            m_rd = (m_rd + 2) % DEPTH;
            m_half = 0;
        end else begin
            if (m_half == 1) m_rd = (m_rd + 1) % DEPTH;
            m_half ^= 1;
        end
        m_wr = (m_wr + 1) % DEPTH;
        m_prev_pitch = pen;
        exp_q.push_back(16'(y));
        tag_q.push_back(tag);
        in_valid   = 1'b1;
        in_sample  = 16'(x);
        mix_coef   = 8'(a);
        pitch_en   = pen;
        pitch_down = pdn;
        @(negedge clk);
        in_valid = 1'b0;
        if (gap > 0) m_last_w = -1;
        repeat (gap) @(negedge clk);
    endtask

    // output monitor, two falling edges after each drive
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R2: actual=unexpected out_valid expected=none");
            end else begin
                check(tag_q.pop_front(), $signed(out_sample), $signed(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
        repeat (3) @(negedge clk);
        check("R1", int'(out_valid), 0); // reset state
        rst_n = 1'b1;
        // R1: strobes during the clearing sweep are ignored
        in_valid = 1'b1;
        in_sample = 16'h1234;
        mix_coef = 8'd200;
        repeat (8) @(negedge clk);
        in_valid = 1'b0;
        repeat (DEPTH + 8) @(negedge clk);
        check("R1", int'(out_valid), 0);
        // R1: every word reads zero after the sweep (a = 0 passes stored)
        for (int i = 0; i < DEPTH; i++) send(1000 + i, 0, 1'b0, 1'b0, 0, "R1");
        // R5/R4: wrap, sample n reads result of n-DEPTH
        for (int i = 0; i < DEPTH + 2; i++) send(-500 * i, 0, 1'b0, 1'b0, i % 2, "R5");
        // R3: coefficient extremes and saturation corners
        send(32767, 255, 1'b0, 1'b0, 1, "R3");
        send(-32768, 255, 1'b0, 1'b0, 0, "R3");
        send(-32768, 128, 1'b0, 1'b0, 0, "R3");
        send(32767, 1, 1'b0, 1'b0, 2, "R3");
        // R8/R6: octave up entered from echo mode
        for (int i = 0; i < 3 * DEPTH; i++) send(i * 77 - 900, 96, 1'b1, 1'b0, i % 3, "");
        // R7: octave down, back-to-back so R10 forwarding also hits
        for (int i = 0; i < 3 * DEPTH; i++) send(4000 - i * 131, 64, 1'b1, 1'b1, 0, "");
        // R9: idle cycles leave the write address alone (echo mode reads it)
        repeat (10) @(negedge clk);
        send(0, 0, 1'b0, 1'b0, 0, "R9");
        // random mix of modes, coefficients and gaps
        for (int run = 0; run < 40; run++) begin
            bit pen, pdn;
            int len;
            pen = 1'($urandom % 2);
            pdn = 1'($urandom % 2);
            len = 1 + int'($urandom % 20);
            for (int k = 0; k < len; k++) begin
                int a, x;
                case ($urandom % 4)
                    0: a = 0;
                    1: a = 255;
                    default: a = int'($urandom % 256);
                endcase
                x = int'($urandom % 65536) - 32768;
                send(x, a, pen, pdn, int'($urandom % 3), "");
            end
        end
        repeat (6) @(negedge clk);
        check("R2", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule